// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel flash device. It takes one request at a time over a valid/ready handshake: an operation code, a target address, a data byte and a choice of completion-detection method. It produces the protected write sequence on the flash pins (chip enable, write enable, output enable, address and data), then keeps reading the device until the operation is finished. It ends the request with a one-cycle done pulse, or with a one-cycle error pulse when the read budget runs out.

Every bus phase lasts `PHASE_CLKS` clocks. A write cycle has three phases: setup, strobe low, then hold. A status read has two phases: output enable low, then a gap. Completion can be detected in two ways. In the bit-7 method, the controller compares bit 7 of the read byte with the value the finished operation leaves there. In the bit-6 method, it treats a stable bit 6 across consecutive reads as finished. In either method, a read that looks finished counts only after a run of further passing reads. This protects against the device changing state part way through a read.

Top module: `flash_wp_ctrl`

## Requirements
- R1: `req_op` 2'b00 or 2'b01 (byte program) produces exactly four write cycles, as (address, data): (05555h, AAh), (02AAAh, 55h), (05555h, A0h), (req_addr, req_data).
- R2: `req_op` 2'b10 (sector erase) produces six write cycles: (05555h, AAh), (02AAAh, 55h), (05555h, 80h), (05555h, AAh), (02AAAh, 55h), then 30h. The address of the last cycle carries req_addr[17:12] and has bits 11..0 zero.
- R3: `req_op` 2'b11 (whole-array erase) produces the same first five cycles as R2, and its sixth cycle is (05555h, 10h).
- R4: During each write cycle, `fl_ce_n` is low, `fl_oe_n` is high and `fl_dq_oe` is high. Address and data are driven for `PHASE_CLKS` clocks before `fl_we_n` falls. `fl_we_n` stays low for exactly `PHASE_CLKS` clocks, with address and data held stable. Data is still driven, unchanged, when `fl_we_n` rises.
- R5: Polling begins only after the final write cycle. Each status read holds `fl_oe_n` low for `PHASE_CLKS` clocks, with `fl_we_n` high and `fl_dq_oe` low. The read address is the address of the last write cycle.
- R6: With `req_toggle`=0, a read passes for a program when read bit 7 equals bit 7 of `req_data`, and for either erase when read bit 7 is 1.
- R7: With `req_toggle`=1, a read passes when its bit 6 equals bit 6 of the immediately preceding read of the same request. The first read of a request never passes.
- R8: `done_pulse` is raised only after `CONFIRM_EXTRA`+1 (default 3) consecutive passing reads. Any failing read restarts the count, so a lone passing read inside a busy period does not end the request.
- R9: If `TIMEOUT_READS` status reads complete without R8 being met, `err_pulse` is raised for one cycle, `done_pulse` is not raised, and no further read is made.
- R10: `req_ready` is high only while no request is in progress. A `req_valid` made while it is low has no effect on the bus. `done_pulse` and `err_pulse` are single-cycle, never raised together, and coincide with `req_ready` returning high.
- R11: After reset, `req_ready` is 1. `fl_ce_n`, `fl_we_n` and `fl_oe_n` are 1. `fl_dq_oe`, `done_pulse` and `err_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request accepted when valid is high |
| req_op | input | 2 | 0x: program, 10: sector erase, 11: whole-array erase |
| req_toggle | input | 1 | 0: bit-7 detection, 1: bit-6 stability detection |
| req_addr | input | 18 | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| done_pulse | output | 1 | Operation confirmed finished |
| err_pulse | output | 1 | Read budget exhausted |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | 18 | Flash address |
| fl_dq_out | output | 8 | Data driven toward flash |
| fl_dq_oe | output | 1 | Data driver enable |
| fl_dq_in | input | 8 | Data read from flash |

## Verification
All three operation codes are run, each against a modelled device that stays busy for a chosen number of reads. The measured read count then shows whether the controller stopped exactly at the first confirmed finish, stopped too early, or stopped too late. Programs are run with data bit 7 at 0 and at 1, so that a bit-7 comparison with the wrong polarity shows up. A single spurious "finished" read is placed inside a busy period, which separates true confirmation from acceptance on the first passing read. The bit-6 method is run with the final bit 6 both matching and differing from the last toggled value, and this shifts the expected read count by one. A device that never finishes is used to expose the read budget, and requests offered during an operation check that the controller ignores them.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam int FL_AW     = 18;
  localparam int FL_DW     = 8;
  localparam int SECT_LSB  = 12;
  localparam int DPOLL_BIT = FL_DW - 1;
  localparam int TOG_BIT   = FL_DW - 2;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WSET = 3'd1,
    ST_WSTB = 3'd2,
    ST_WHLD = 3'd3,
    ST_RACC = 3'd4,
    ST_RGAP = 3'd5
  } fpc_state_e;

  typedef struct packed {
    logic [FL_AW-1:0] addr;
    logic [FL_DW-1:0] data;
  } bus_word_t;

  // op[1] selects erase; op[0] then selects whole-array over sector
  function automatic logic [2:0] seq_last(input logic [1:0] op);
    return op[1] ? 3'd5 : 3'd3;
  endfunction

  function automatic logic [FL_AW-1:0] sector_base(input logic [FL_AW-1:0] a);
    return {a[FL_AW-1:SECT_LSB], {SECT_LSB{1'b0}}};
  endfunction

  function automatic bus_word_t seq_word(input logic [1:0] op, input logic [2:0] idx,
                                         input logic [FL_AW-1:0] a,
                                         input logic [FL_DW-1:0] d);
    bus_word_t w;
    w.addr = FL_AW'(18'h05555);
    w.data = FL_DW'(8'hAA);
    case (idx)
      3'd1, 3'd4: begin
        w.addr = FL_AW'(18'h02AAA);
        w.data = FL_DW'(8'h55);
      end
      3'd2: w.data = op[1] ? FL_DW'(8'h80) : FL_DW'(8'hA0);
      3'd3: if (!op[1]) begin
        w.addr = a;
        w.data = d;
      end
      3'd5: begin
        if (!op[0]) w.addr = sector_base(a);
        w.data = op[0] ? FL_DW'(8'h10) : FL_DW'(8'h30);
      end
      default: ;
    endcase
    return w;
  endfunction

  function automatic logic poll_bit7_ok(input logic [1:0] op, input logic rd7,
                                        input logic wr7);
    return op[1] ? rd7 : (rd7 == wr7);
  endfunction

endpackage

// File: rtl/fpc_phase_timer.sv
module fpc_phase_timer #(
  parameter int PHASE_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_end
);
  localparam int CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;

  logic [CW-1:0] cnt_q;

  assign phase_end = run && (cnt_q == CW'(PHASE_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run || phase_end) cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/fpc_cmd_gen.sv
module fpc_cmd_gen
  import fpc_pkg::*;
(
  input  logic [1:0]       op,
  input  logic [2:0]       idx,
  input  logic [FL_AW-1:0] addr,
  input  logic [FL_DW-1:0] data,
  output bus_word_t        cur_word,
  output logic [FL_AW-1:0] poll_addr,
  output logic             is_last
);
  bus_word_t last_word;

  assign cur_word  = seq_word(op, idx, addr, data);
  assign last_word = seq_word(op, seq_last(op), addr, data);
  assign poll_addr = last_word.addr;
  assign is_last   = (idx == seq_last(op));
endmodule

// File: rtl/fpc_poll_judge.sv
module fpc_poll_judge
  import fpc_pkg::*;
#(
  parameter int TIMEOUT_READS = 4096,
  parameter int CONFIRM_EXTRA = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample,
  input  logic             toggle,
  input  logic [1:0]       op,
  input  logic             wr_msb,
  input  logic [FL_DW-1:0] rd_data,
  output logic             pass_now,
  output logic             complete,
  output logic             expired
);
  localparam int NW = $clog2(TIMEOUT_READS + 1);

  logic          prev_tog_q;
  logic          have_prev_q;
  logic [NW-1:0] nreads_q;

  always_comb begin
    if (toggle) pass_now = have_prev_q && (rd_data[TOG_BIT] == prev_tog_q);
    else        pass_now = poll_bit7_ok(op, rd_data[DPOLL_BIT], wr_msb);
  end

  assign expired = sample && !complete && (nreads_q == NW'(TIMEOUT_READS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_tog_q  <= 1'b0;
      have_prev_q <= 1'b0;
      nreads_q    <= '0;
    end else if (clear) begin
      have_prev_q <= 1'b0;
      nreads_q    <= '0;
    end else if (sample) begin
      prev_tog_q  <= rd_data[TOG_BIT];
      have_prev_q <= 1'b1;
      nreads_q    <= nreads_q + NW'(1);
    end
  end

  generate
    if (CONFIRM_EXTRA == 0) begin : g_noconf
      assign complete = sample && pass_now;
    end else begin : g_conf
      localparam int CFW = $clog2(CONFIRM_EXTRA + 2);
      logic [CFW-1:0] conf_q;
      assign complete = sample && pass_now && (conf_q == CFW'(CONFIRM_EXTRA));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      conf_q <= '0;
        else if (clear)  conf_q <= '0;
        else if (sample) conf_q <= pass_now ? conf_q + CFW'(1) : '0;
      end
    end
  endgenerate
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import fpc_pkg::*;
#(
  parameter int PHASE_CLKS    = 2,
  parameter int TIMEOUT_READS = 4096,
  parameter int CONFIRM_EXTRA = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic             req_toggle,
  input  logic [FL_AW-1:0] req_addr,
  input  logic [FL_DW-1:0] req_data,
  output logic             done_pulse,
  output logic             err_pulse,
  output logic             fl_ce_n,
  output logic             fl_we_n,
  output logic             fl_oe_n,
  output logic [FL_AW-1:0] fl_addr,
  output logic [FL_DW-1:0] fl_dq_out,
  output logic             fl_dq_oe,
  input  logic [FL_DW-1:0] fl_dq_in
);
  fpc_state_e       st_q;
  logic [1:0]       op_q;
  logic             tog_q;
  logic [FL_AW-1:0] addr_q;
  logic [FL_DW-1:0] data_q;
  logic [2:0]       cyc_q;

  // named internal events
  logic             phase_end;
  logic             accept;
  logic             in_write;
  logic             in_read;
  logic             sample_rd;
  logic             last_cycle;
  logic             poll_pass;
  logic             poll_complete;
  logic             poll_expired;
  bus_word_t        cur_word;
  logic [FL_AW-1:0] poll_addr;

  assign accept    = req_ready && req_valid;
  assign in_write  = (st_q == ST_WSET) || (st_q == ST_WSTB) || (st_q == ST_WHLD);
  assign in_read   = (st_q == ST_RACC) || (st_q == ST_RGAP);
  assign sample_rd = (st_q == ST_RACC) && phase_end;

  fpc_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (st_q != ST_IDLE),
    .phase_end (phase_end)
  );

  fpc_cmd_gen u_cmd (
    .op        (op_q),
    .idx       (cyc_q),
    .addr      (addr_q),
    .data      (data_q),
    .cur_word  (cur_word),
    .poll_addr (poll_addr),
    .is_last   (last_cycle)
  );

  fpc_poll_judge #(
    .TIMEOUT_READS (TIMEOUT_READS),
    .CONFIRM_EXTRA (CONFIRM_EXTRA)
  ) u_judge (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .sample   (sample_rd),
    .toggle   (tog_q),
    .op       (op_q),
    .wr_msb   (data_q[DPOLL_BIT]),
    .rd_data  (fl_dq_in),
    .pass_now (poll_pass),
    .complete (poll_complete),
    .expired  (poll_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      op_q       <= '0;
      tog_q      <= 1'b0;
      addr_q     <= '0;
      data_q     <= '0;
      cyc_q      <= '0;
      done_pulse <= 1'b0;
      err_pulse  <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      err_pulse  <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid) begin
          op_q   <= req_op;
          tog_q  <= req_toggle;
          addr_q <= req_addr;
          data_q <= req_data;
          cyc_q  <= '0;
          st_q   <= ST_WSET;
        end
        ST_WSET: if (phase_end) st_q <= ST_WSTB;
        ST_WSTB: if (phase_end) st_q <= ST_WHLD;
        ST_WHLD: if (phase_end) begin
          if (last_cycle) st_q <= ST_RACC;
          else begin
            cyc_q <= cyc_q + 3'd1;
            st_q  <= ST_WSET;
          end
        end
        ST_RACC: if (phase_end) begin
          if (poll_complete) begin
            done_pulse <= 1'b1;
            st_q       <= ST_IDLE;
          end else if (poll_expired) begin
            err_pulse <= 1'b1;
            st_q      <= ST_IDLE;
          end else begin
            st_q <= ST_RGAP;
          end
        end
        ST_RGAP: if (phase_end) st_q <= ST_RACC;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign fl_ce_n   = (st_q == ST_IDLE);
  assign fl_we_n   = (st_q != ST_WSTB);
  assign fl_oe_n   = (st_q != ST_RACC);
  assign fl_dq_oe  = in_write;
  assign fl_dq_out = in_write ? cur_word.data : '0;

  always_comb begin
    if (in_write)     fl_addr = cur_word.addr;
    else if (in_read) fl_addr = poll_addr;
    else              fl_addr = '0;
  end
endmodule

// File: rtl/fpc_chk.sv
module fpc_chk
  import fpc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             done_pulse,
  input logic             err_pulse,
  input logic             fl_ce_n,
  input logic             fl_we_n,
  input logic             fl_oe_n,
  input logic [FL_AW-1:0] fl_addr,
  input logic [FL_DW-1:0] fl_dq_out,
  input logic             fl_dq_oe,
  input logic             poll_complete,
  input logic             poll_expired
);
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (fl_oe_n && fl_dq_oe && !fl_ce_n));

  // R4
  strobe_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

  // R4
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (fl_dq_oe && $stable(fl_dq_out) && $stable(fl_addr)));

  // R5
  read_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> (fl_we_n && !fl_dq_oe && !fl_ce_n));

  // R8
  confirm_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_complete |=> done_pulse);

  // R9
  budget_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_expired |=> (err_pulse && !done_pulse));

  // R10
  end_pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_pulse, err_pulse}));

  // R10
  end_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse || err_pulse) |-> req_ready);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe));
endmodule

bind flash_wp_ctrl fpc_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .done_pulse    (done_pulse),
  .err_pulse     (err_pulse),
  .fl_ce_n       (fl_ce_n),
  .fl_we_n       (fl_we_n),
  .fl_oe_n       (fl_oe_n),
  .fl_addr       (fl_addr),
  .fl_dq_out     (fl_dq_out),
  .fl_dq_oe      (fl_dq_oe),
  .poll_complete (poll_complete),
  .poll_expired  (poll_expired)
);

// File: tb/sim_flash_wp_ctrl.sv
`timescale 1ns/1ps
module sim_flash_wp_ctrl;
  import fpc_pkg::*;

  localparam int PH = 2;
  localparam int TO = 40;
  localparam int CE = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic        req_toggle = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic        done_pulse, err_pulse;
  logic        fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
  logic [17:0] fl_addr;
  logic [7:0]  fl_dq_out;
  logic [7:0]  fl_dq_in;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  flash_wp_ctrl #(.PHASE_CLKS(PH), .TIMEOUT_READS(TO), .CONFIRM_EXTRA(CE)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_toggle(req_toggle), .req_addr(req_addr), .req_data(req_data),
    .done_pulse(done_pulse), .err_pulse(err_pulse), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
    .fl_oe_n(fl_oe_n), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in));

  // ---------------- device model ----------------
  int          rd_idx = 0;
  int          busy_n = 0;
  int          glitch_at = -1;
  logic        m_prog = 1'b1;
  logic [7:0]  m_final = 8'hFF;
  int          nwr = 0;
  logic [17:0] wa [8];
  logic [7:0]  wd [8];
  logic        we_q = 1'b1, oe_q = 1'b1;

  always_comb begin
    if (rd_idx < busy_n && rd_idx != glitch_at)
      fl_dq_in = {(m_prog ? ~m_final[7] : 1'b0), 1'((rd_idx & 1) != 0), 6'b0};
    else
      fl_dq_in = m_final;
  end

  always @(posedge clk) begin
    we_q <= fl_we_n;
    oe_q <= fl_oe_n;
    if (!we_q && fl_we_n && nwr < 8) begin
      wa[nwr] <= fl_addr;
      wd[nwr] <= fl_dq_out;
      nwr <= nwr + 1;
    end
    if (!oe_q && fl_oe_n) rd_idx <= rd_idx + 1;
  end

  // ---------------- bus monitor ----------------
  int          viol = 0;
  int          rd_bad = 0;
  int          low_run = 0;
  logic [17:0] exp_poll_addr = '0;
  logic [17:0] pa = '0;
  logic [7:0]  pd = '0;
  logic        p_drv = 1'b0;
  logic        p_we_n = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!fl_we_n) begin
        low_run = low_run + 1;
        if (!fl_oe_n || !fl_dq_oe || fl_ce_n) viol = viol + 1;
        if (pa != fl_addr || pd != fl_dq_out || !p_drv) viol = viol + 1;
      end else if (!p_we_n) begin
        if (low_run != PH) viol = viol + 1;
        if (!fl_dq_oe || fl_dq_out != pd || fl_addr != pa) viol = viol + 1;
        low_run = 0;
      end
      if (!fl_oe_n && (fl_addr != exp_poll_addr || fl_dq_oe || !fl_we_n)) rd_bad = rd_bad + 1;
    end
    pa = fl_addr; pd = fl_dq_out; p_drv = fl_dq_oe && !fl_ce_n; p_we_n = fl_we_n;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_seq(input logic [1:0] op, input logic [17:0] a, input logic [7:0] d,
                           input string tag);
    int n = op[1] ? 6 : 4;
    int mism = 0;
    check(nwr == n, {tag, " write count"}, nwr, n);
    for (int i = 0; i < n && i < nwr; i++) begin
      logic [17:0] ea;
      logic [7:0]  ed;
      case (i)
        0: begin ea = 18'h05555; ed = 8'hAA; end
        1: begin ea = 18'h02AAA; ed = 8'h55; end
        2: begin ea = 18'h05555; ed = op[1] ? 8'h80 : 8'hA0; end
        3: if (op[1]) begin ea = 18'h05555; ed = 8'hAA; end else begin ea = a; ed = d; end
        4: begin ea = 18'h02AAA; ed = 8'h55; end
        default: if (op[0]) begin ea = 18'h05555; ed = 8'h10; end
                 else begin ea = {a[17:12], 12'h000}; ed = 8'h30; end
      endcase
      if (wa[i] != ea || wd[i] != ed) begin
        if (mism == 0) check(1'b0, {tag, " write word"}, {wa[i], wd[i]}, {ea, ed});
        mism++;
      end
    end
    check(mism == 0, {tag, " sequence"}, mism, 0);
  endtask

  task automatic run_op(input logic [1:0] op, input bit tog, input logic [17:0] a,
                        input logic [7:0] d, input logic [7:0] fin, input int busy,
                        input int glitch, input bit poke, output bit gd, output bit ge);
    int n = 0;
    @(negedge clk);
    nwr = 0; rd_idx = 0; busy_n = busy; glitch_at = glitch;
    m_prog = !op[1]; m_final = fin; viol = 0; rd_bad = 0;
    exp_poll_addr = (op == 2'b11) ? 18'h05555 : (op == 2'b10) ? {a[17:12], 12'h000} : a;
    req_op = op; req_toggle = tog; req_addr = a; req_data = d; req_valid = 1'b1;
    check(req_ready == 1'b1, "R10 ready when idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b11;
        check(req_ready == 1'b0, "R10 ready low while busy", req_ready, 0);
      end
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done_pulse && !err_pulse && n < 60000) begin
      @(negedge clk);
      n++;
    end
    gd = done_pulse; ge = err_pulse;
    check(n < 60000, "R10 request finished", n, 60000);
    check(req_ready == 1'b1, "R10 ready with end pulse", req_ready, 1);
    @(negedge clk);
    check(!done_pulse && !err_pulse, "R10 single-cycle end pulse", {done_pulse, err_pulse}, 0);
    @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    check(req_ready && fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe && !done_pulse && !err_pulse,
          "R11 reset state",
          {req_ready, fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe, done_pulse, err_pulse}, 7'b1111000);
  endtask

  task automatic t_dpoll(input logic [1:0] op, input logic [17:0] a, input logic [7:0] d,
                         input int busy, input string tag);
    bit gd, ge;
    logic [7:0] fin = op[1] ? 8'hFF : d;
    run_op(op, 1'b0, a, d, fin, busy, -1, 1'b0, gd, ge);
    check_seq(op, a, d, tag);
    check(gd && !ge, "R6 done in bit-7 mode", {gd, ge}, 2'b10);
    check(rd_idx == busy + 1 + CE, "R6 R8 read count", rd_idx, busy + 1 + CE);
    check(viol == 0, "R4 write timing", viol, 0);
    check(rd_bad == 0, "R5 read address and drive", rd_bad, 0);
  endtask

  task automatic t_glitch;
    bit gd, ge;
    run_op(2'b00, 1'b0, 18'h1F00F, 8'h96, 8'h96, 8, 3, 1'b0, gd, ge);
    check(gd && !ge, "R8 done after glitch", {gd, ge}, 2'b10);
    check(rd_idx == 8 + 1 + CE, "R8 spurious pass ignored", rd_idx, 8 + 1 + CE);
  endtask

  task automatic t_toggle(input logic [1:0] op, input logic [7:0] d, input int busy);
    bit gd, ge;
    logic [7:0] fin = op[1] ? 8'hFF : d;
    int extra = (fin[6] == ((busy - 1) % 2 == 1)) ? 1 + CE : 2 + CE;
    run_op(op, 1'b1, 18'h00123, d, fin, busy, -1, 1'b0, gd, ge);
    check(gd && !ge, "R7 done in bit-6 mode", {gd, ge}, 2'b10);
    check(rd_idx == busy + extra, "R7 R8 toggle read count", rd_idx, busy + extra);
  endtask

  task automatic t_timeout;
    bit gd, ge;
    run_op(2'b00, 1'b0, 18'h00042, 8'h11, 8'h11, 100000, -1, 1'b0, gd, ge);
    check(ge && !gd, "R9 error pulse", {gd, ge}, 2'b01);
    check(rd_idx == TO, "R9 read budget", rd_idx, TO);
  endtask

  task automatic t_busy_ignore;
    bit gd, ge;
    run_op(2'b01, 1'b0, 18'h2AA55, 8'h5A, 8'h5A, 2, -1, 1'b1, gd, ge);
    check(gd, "R10 op ends normally", gd, 1);
    check(nwr == 4, "R10 busy request ignored", nwr, 4);
    check_seq(2'b01, 18'h2AA55, 8'h5A, "R10 R1");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_dpoll(2'b00, 18'h3F0A5, 8'h3C, 5, "R1");
    t_dpoll(2'b01, 18'h00007, 8'hA5, 3, "R1");
    t_dpoll(2'b10, 18'h2B7C1, 8'h00, 4, "R2");
    t_dpoll(2'b11, 18'h3FFFF, 8'h00, 0, "R3");
    t_glitch;
    t_toggle(2'b00, 8'h40, 6);
    t_toggle(2'b10, 8'h00, 5);
    t_timeout;
    t_busy_ignore;
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule